// File: doc/BRIEF.md
# Keyed Index/Data Configuration Port

This block implements a legacy configuration interface on an 8-bit I/O bus with a 16-bit address. Two addresses are claimed: an index port that selects a configuration register and a data port that reads or writes the selected register. Access is locked after reset. Software opens it by writing a fixed four-byte key to the index port, and closes it again with a two-step write sequence.

While the port is open, it holds a logical-device selector and a read-only chip identifier and revision. It also holds a banked window of configuration registers. The window shows one copy per logical device, chosen by the selector. Every banked register is exported in parallel, so the function blocks behind each logical device can use their own settings directly. By convention, logical device 7 is the general-purpose I/O function.

Reads return data combinationally in the same cycle as the read strobe. Writes take effect at the clock edge that samples the write strobe. Because software updates registers by read, modify and write, every writable register reads back exactly the value last written.

Top module: `keyed_cfg_port`

## Requirements
- R1: After reset the port is locked, the latched index is 0x00, the device selector is 0x00 and every exported bank register is 0x00.
- R2: The index port is I/O address 0x002E and the data port is 0x002F. Writing 0x87, 0x01, 0x55, 0x55 in succession to the index port opens the port.
- R3: While locked, any other byte written to the index port restarts key detection from the beginning. A byte of 0x87 counts as the first key byte, so 0x87, 0x01, 0x55, 0x87, 0x01, 0x55, 0x55 opens the port.
- R4: While locked, reads of either port return 0xFF. Data-port writes are ignored, and index-port writes do not change the latched index.
- R5: While open, an index-port write latches the byte as the index, and an index-port read returns the latched index.
- R6: Index 0x07 is the device selector. It is a full 8-bit read/write register.
- R7: Index 0x20 returns the high byte of the 16-bit chip identifier and index 0x21 returns its low byte. Writes to either index are ignored.
- R8: Index 0x22 returns the 4-bit revision in bits 3:0 with bits 7:4 zero. Writes to it are ignored.
- R9: Indices 0x60 to 0x6F address the bank of the device named by the selector, and each entry reads back the last value written. Device d register r appears on ldev_cfg bits [(d*16+r)*8 +: 8].
- R10: When the selector is 8 or higher, bank writes are ignored and bank reads return 0x00.
- R11: Unimplemented indices read 0x00, and writes to them change no state.
- R12: While open, selecting index 0x02 and then writing 0x02 to the data port locks the port. Any other value written at index 0x02 leaves it open. Reopening needs the full key again.
- R13: Reads of any other address, and io_rdata whenever io_rd is low, return 0x00. Writes to other addresses neither change state nor disturb key detection.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 16 | I/O address |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_rd | input | 1 | Read strobe, one cycle per read |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, valid in the cycle of io_rd |
| ldev_cfg | output | 1024 | All bank registers, device-major, 8 bits each |

## Verification
The assertions assume the bus never raises io_wr and io_rd in the same cycle, and that each strobe lasts one clock per access. Under those conditions, one key byte or one register access corresponds to exactly one sampled edge. The bench's write and read tasks drive each strobe for a single cycle, starting from a falling edge, and never overlap the two strobes. Stray writes to foreign addresses are kept inside single accesses too, so the key-progress checks see a clean sequence of index-port writes.

// File: rtl/keyed_cfg_pkg.sv
package keyed_cfg_pkg;

   localparam logic [7:0] IDX_EXIT  = 8'h02;
   localparam logic [7:0] EXIT_VAL  = 8'h02;
   localparam logic [7:0] IDX_LDSEL = 8'h07;
   localparam logic [7:0] IDX_ID_HI = 8'h20;
   localparam logic [7:0] IDX_ID_LO = 8'h21;
   localparam logic [7:0] IDX_REV   = 8'h22;
   localparam logic [7:0] LOCKED_RD = 8'hFF;

   typedef enum logic [2:0] {
      KS_IDLE = 3'd0,
      KS_GOT1 = 3'd1,
      KS_GOT2 = 3'd2,
      KS_GOT3 = 3'd3,
      KS_OPEN = 3'd4
   } key_state_t;

   // Expected key byte for each step of the unlock sequence
   function automatic logic [7:0] key_byte(input logic [1:0] step);
      case (step)
         2'd0:    key_byte = 8'h87;
         2'd1:    key_byte = 8'h01;
         default: key_byte = 8'h55;
      endcase
   endfunction

endpackage

// File: rtl/keyed_cfg_key_fsm.sv
module keyed_cfg_key_fsm
   import keyed_cfg_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       idx_wr,
   input  logic [7:0] wdata,
   input  logic       exit_req,
   output logic       open
);

   key_state_t state_q, state_d;

   always_comb begin
      state_d = state_q;
      if (state_q == KS_OPEN) begin
         if (exit_req) state_d = KS_IDLE;
      end else if (idx_wr) begin
         if (wdata == key_byte(state_q[1:0])) begin
            state_d = (state_q == KS_GOT3) ? KS_OPEN : key_state_t'(state_q + 3'd1);
         end else if (wdata == key_byte(2'd0)) begin
            state_d = KS_GOT1;
         end else begin
            state_d = KS_IDLE;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= KS_IDLE;
      else        state_q <= state_d;
   end

   assign open = (state_q == KS_OPEN);

   // R2
   key_complete_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == KS_GOT3 && idx_wr && wdata == 8'h55) |=> open);

   // R3
   key_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!open && idx_wr && wdata == 8'h87 && state_q != KS_GOT3) |=> (state_q == KS_GOT1));

   // R12
   exit_relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (open && exit_req) |=> !open);

   // R12
   open_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (open && !exit_req) |=> open);

endmodule

// File: rtl/keyed_cfg_bank.sv
module keyed_cfg_bank #(
   parameter int NUM_LDEV  = 8,
   parameter int BANK_REGS = 16,
   localparam int ENTRIES  = NUM_LDEV * BANK_REGS,
   localparam int SEL_W    = $clog2(ENTRIES)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 we,
   input  logic [SEL_W-1:0]     sel,
   input  logic [7:0]           wdata,
   output logic [7:0]           rd_byte,
   output logic [ENTRIES*8-1:0] flat
);

   logic [7:0] regs_q [ENTRIES];

   for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                          regs_q[e] <= 8'h00;
         else if (we && sel == SEL_W'(e))     regs_q[e] <= wdata;
      end
      assign flat[e*8 +: 8] = regs_q[e];
   end

   assign rd_byte = regs_q[sel];

   // R9
   bank_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (regs_q[$past(sel)] == $past(wdata)));

endmodule

// File: rtl/keyed_cfg_read_mux.sv
module keyed_cfg_read_mux
   import keyed_cfg_pkg::*;
#(
   parameter logic [15:0] CHIP_ID  = 16'hA5C3,
   parameter logic [3:0]  CHIP_REV = 4'h6
) (
   input  logic       rd,
   input  logic       hit_idx,
   input  logic       hit_data,
   input  logic       open,
   input  logic [7:0] idx,
   input  logic [7:0] ldsel,
   input  logic       bank_ok,
   input  logic [7:0] bank_byte,
   output logic [7:0] rdata
);

   logic [7:0] reg_val;

   always_comb begin
      case (idx)
         IDX_LDSEL: reg_val = ldsel;
         IDX_ID_HI: reg_val = CHIP_ID[15:8];
         IDX_ID_LO: reg_val = CHIP_ID[7:0];
         IDX_REV:   reg_val = {4'h0, CHIP_REV};
         default:   reg_val = bank_ok ? bank_byte : 8'h00;
      endcase
   end

   always_comb begin
      rdata = 8'h00;
      if (rd) begin
         if (hit_idx)       rdata = open ? idx : LOCKED_RD;
         else if (hit_data) rdata = open ? reg_val : LOCKED_RD;
      end
   end

endmodule

// File: rtl/keyed_cfg_port.sv
module keyed_cfg_port
   import keyed_cfg_pkg::*;
#(
   parameter logic [15:0] IDX_PORT   = 16'h002E,
   parameter logic [15:0] DATA_PORT  = 16'h002F,
   parameter logic [15:0] CHIP_ID    = 16'hA5C3,
   parameter logic [3:0]  CHIP_REV   = 4'h6,
   parameter int          NUM_LDEV   = 8,
   parameter int          BANK_REGS  = 16,
   parameter logic [7:0]  BANK_BASE  = 8'h60,
   localparam int         OFF_W      = $clog2(BANK_REGS),
   localparam int         LD_W       = $clog2(NUM_LDEV),
   localparam int         CFG_W      = NUM_LDEV * BANK_REGS * 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [15:0]      io_addr,
   input  logic             io_wr,
   input  logic             io_rd,
   input  logic [7:0]       io_wdata,
   output logic [7:0]       io_rdata,
   output logic [CFG_W-1:0] ldev_cfg
);

   // Elaboration-time parameter checks
   if (BANK_REGS < 2 || (BANK_REGS & (BANK_REGS - 1)) != 0) begin : g_bad_regs
      $error("BANK_REGS must be a power of two of at least 2");
   end
   if (NUM_LDEV < 2 || NUM_LDEV > 128 || (NUM_LDEV & (NUM_LDEV - 1)) != 0) begin : g_bad_ldev
      $error("NUM_LDEV must be a power of two from 2 to 128");
   end
   if ((int'(BANK_BASE) % BANK_REGS) != 0 || int'(BANK_BASE) + BANK_REGS > 256
       || BANK_BASE < 8'h30) begin : g_bad_base
      $error("BANK_BASE must be aligned, above 0x2F and fit in the index space");
   end

   logic       hit_idx, hit_data, open, exit_req;
   logic       idx_wr, data_wr, in_bank, dev_ok, bank_we;
   logic [7:0] idx_q, ldsel_q, bank_byte;

   assign hit_idx  = (io_addr == IDX_PORT);
   assign hit_data = (io_addr == DATA_PORT);
   assign idx_wr   = io_wr && hit_idx;
   assign data_wr  = io_wr && hit_data && open;
   assign exit_req = data_wr && idx_q == IDX_EXIT && io_wdata == EXIT_VAL;
   assign in_bank  = (idx_q[7:OFF_W] == BANK_BASE[7:OFF_W]);
   assign dev_ok   = (ldsel_q[7:LD_W] == '0);
   assign bank_we  = data_wr && in_bank && dev_ok;

   keyed_cfg_key_fsm u_key (
      .clk      (clk),
      .rst_n    (rst_n),
      .idx_wr   (idx_wr),
      .wdata    (io_wdata),
      .exit_req (exit_req),
      .open     (open)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q   <= 8'h00;
         ldsel_q <= 8'h00;
      end else begin
         if (idx_wr && open)                   idx_q   <= io_wdata;
         if (data_wr && idx_q == IDX_LDSEL)    ldsel_q <= io_wdata;
      end
   end

   keyed_cfg_bank #(
      .NUM_LDEV  (NUM_LDEV),
      .BANK_REGS (BANK_REGS)
   ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (bank_we),
      .sel     ({ldsel_q[LD_W-1:0], idx_q[OFF_W-1:0]}),
      .wdata   (io_wdata),
      .rd_byte (bank_byte),
      .flat    (ldev_cfg)
   );

   keyed_cfg_read_mux #(
      .CHIP_ID  (CHIP_ID),
      .CHIP_REV (CHIP_REV)
   ) u_rmux (
      .rd        (io_rd),
      .hit_idx   (hit_idx),
      .hit_data  (hit_data),
      .open      (open),
      .idx       (idx_q),
      .ldsel     (ldsel_q),
      .bank_ok   (in_bank && dev_ok),
      .bank_byte (bank_byte),
      .rdata     (io_rdata)
   );

   // R4
   locked_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!open && io_wr && hit_data) |=> ($stable(ldev_cfg) && $stable(ldsel_q)));

   // R4
   locked_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!open && io_rd && (hit_idx || hit_data)) |-> (io_rdata == 8'hFF));

   // R6
   ldsel_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr && idx_q == IDX_LDSEL) |=> (ldsel_q == $past(io_wdata)));

   // R13
   idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!io_rd || (!hit_idx && !hit_data)) |-> (io_rdata == 8'h00));

   // R10
   bad_dev_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && !dev_ok) |=> $stable(ldev_cfg));

endmodule

// File: tb/keyed_cfg_port_bench.sv
module keyed_cfg_port_bench;

   localparam logic [15:0] P_IDX  = 16'h002E;
   localparam logic [15:0] P_DAT  = 16'h002F;
   localparam logic [15:0] T_ID   = 16'hA5C3;
   localparam logic [3:0]  T_REV  = 4'h6;
   localparam int          CFG_W  = 8 * 16 * 8;

   localparam logic [1:0] WI = 2'd0, WD = 2'd1, RI = 2'd2, RD = 2'd3;
   localparam int NV = 30;
   // {op, data, expected}
   localparam logic [17:0] VEC [NV] = '{
      {WI, 8'h87, 8'h00}, {WI, 8'h01, 8'h00},               // R2 key
      {WI, 8'h55, 8'h00}, {WI, 8'h55, 8'h00},
      {RI, 8'h00, 8'h00},                                   // R2/R5 open, index 0
      {WI, 8'h07, 8'h00}, {RI, 8'h00, 8'h07},               // R5
      {WD, 8'h05, 8'h00}, {RD, 8'h00, 8'h05},               // R6
      {WI, 8'h20, 8'h00}, {RD, 8'h00, 8'hA5},               // R7 high
      {WI, 8'h21, 8'h00}, {RD, 8'h00, 8'hC3},               // R7 low
      {WD, 8'hAA, 8'h00}, {RD, 8'h00, 8'hC3},               // R7 read-only
      {WI, 8'h22, 8'h00}, {WD, 8'hFF, 8'h00},
      {RD, 8'h00, 8'h06},                                   // R8
      {WI, 8'h07, 8'h00}, {WD, 8'h03, 8'h00},               // select device 3
      {WI, 8'h61, 8'h00}, {WD, 8'h3C, 8'h00},
      {RD, 8'h00, 8'h3C},                                   // R9
      {WI, 8'h07, 8'h00}, {WD, 8'h04, 8'h00},               // device 4
      {WI, 8'h61, 8'h00}, {RD, 8'h00, 8'h00},               // R9 separate copy
      {WI, 8'h40, 8'h00}, {WD, 8'h77, 8'h00},
      {RD, 8'h00, 8'h00}                                    // R11
   };

   logic             clk, rst_n, io_wr, io_rd;
   logic [15:0]      io_addr;
   logic [7:0]       io_wdata, io_rdata;
   logic [CFG_W-1:0] ldev_cfg;
   logic [CFG_W-1:0] snap;
   int checks = 0, errors = 0;

   keyed_cfg_port #(
      .IDX_PORT (P_IDX), .DATA_PORT (P_DAT), .CHIP_ID (T_ID), .CHIP_REV (T_REV),
      .NUM_LDEV (8), .BANK_REGS (16), .BANK_BASE (8'h60)
   ) u_keyed_cfg_port (
      .clk (clk), .rst_n (rst_n), .io_addr (io_addr), .io_wr (io_wr),
      .io_rd (io_rd), .io_wdata (io_wdata), .io_rdata (io_rdata),
      .ldev_cfg (ldev_cfg)
   );

   initial clk = 1'b0;
   always #2 clk = ~clk;

   task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %02h expected %02h", tag, act, exp);
      end
   endtask

   task automatic io_write(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      io_addr = a; io_wdata = d; io_wr = 1'b1;
      @(negedge clk);
      io_wr = 1'b0; io_addr = 16'h0000;
   endtask

   task automatic io_read(input logic [15:0] a, input string tag, input logic [7:0] exp);
      @(negedge clk);
      io_addr = a; io_rd = 1'b1;
      #1;
      check8(tag, io_rdata, exp);
      @(negedge clk);
      io_rd = 1'b0; io_addr = 16'h0000;
   endtask

   task automatic unlock();
      io_write(P_IDX, 8'h87); io_write(P_IDX, 8'h01);
      io_write(P_IDX, 8'h55); io_write(P_IDX, 8'h55);
   endtask

   initial begin
      #(200000 * 4);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      rst_n = 1'b0; io_wr = 1'b0; io_rd = 1'b0; io_addr = 16'h0; io_wdata = 8'h0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      checks++;
      if (ldev_cfg !== '0) begin
         errors++; $display("FAIL R1: bank got nonzero expected 0");
      end
      io_read(P_DAT, "R1 locked data", 8'hFF);
      io_read(P_IDX, "R1 locked index", 8'hFF);

      // Table walk
      for (int i = 0; i < NV; i++) begin
         logic [1:0] op;
         op = VEC[i][17:16];
         case (op)
            WI: io_write(P_IDX, VEC[i][15:8]);
            WD: io_write(P_DAT, VEC[i][15:8]);
            RI: io_read(P_IDX, $sformatf("table[%0d]", i), VEC[i][7:0]);
            default: io_read(P_DAT, $sformatf("table[%0d]", i), VEC[i][7:0]);
         endcase
      end

      // R9 export position: device 3 register 1
      check8("R9 export", ldev_cfg[(3*16+1)*8 +: 8], 8'h3C);
      // R11 no state change from unimplemented write
      check8("R11 device 4 reg 0", ldev_cfg[(4*16+0)*8 +: 8], 8'h00);

      // R10 selector out of range
      snap = ldev_cfg;
      io_write(P_IDX, 8'h07); io_write(P_DAT, 8'h09);
      io_read(P_DAT, "R6 full width selector", 8'h09);
      io_write(P_IDX, 8'h61); io_write(P_DAT, 8'hEE);
      io_read(P_DAT, "R10 read", 8'h00);
      checks++;
      if (ldev_cfg !== snap) begin
         errors++; $display("FAIL R10: bank changed expected unchanged");
      end

      // R13 foreign address
      io_read(16'h0080, "R13 foreign read", 8'h00);

      // R12 exit
      io_write(P_IDX, 8'h02); io_write(P_DAT, 8'h55);
      io_read(P_IDX, "R12 other value stays open", 8'h02);
      io_write(P_DAT, 8'h02);
      io_read(P_IDX, "R12 locked after exit", 8'hFF);

      // R4 locked writes ignored
      snap = ldev_cfg;
      io_write(P_DAT, 8'h99);
      io_write(P_IDX, 8'h30);
      checks++;
      if (ldev_cfg !== snap) begin
         errors++; $display("FAIL R4: bank changed expected unchanged");
      end

      // R3 wrong byte restarts
      io_write(P_IDX, 8'h87); io_write(P_IDX, 8'h01); io_write(P_IDX, 8'h33);
      io_write(P_IDX, 8'h55); io_write(P_IDX, 8'h55);
      io_read(P_IDX, "R3 broken key stays locked", 8'hFF);
      // R3 0x87 restarts at step one
      io_write(P_IDX, 8'h87); io_write(P_IDX, 8'h01); io_write(P_IDX, 8'h55);
      io_write(P_IDX, 8'h87); io_write(P_IDX, 8'h01); io_write(P_IDX, 8'h55);
      io_write(P_IDX, 8'h55);
      io_read(P_IDX, "R4 index kept while locked", 8'h02);
      io_write(P_IDX, 8'h07);
      io_read(P_DAT, "R4 selector kept while locked", 8'h09);

      // R13 foreign writes do not disturb the key
      io_write(P_IDX, 8'h02); io_write(P_DAT, 8'h02);
      io_write(P_IDX, 8'h87); io_write(P_IDX, 8'h01);
      io_write(16'h0080, 8'h00);
      io_write(P_IDX, 8'h55); io_write(P_IDX, 8'h55);
      io_read(P_IDX, "R13 key across foreign write", 8'h02);
      io_write(16'h0080, 8'h11);
      io_read(P_IDX, "R13 foreign write no effect", 8'h02);

      // R1 reset again mid-session
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      unlock();
      io_read(P_IDX, "R1 index after reset", 8'h00);
      io_write(P_IDX, 8'h07);
      io_read(P_DAT, "R1 selector after reset", 8'h00);
      check8("R1 bank after reset", ldev_cfg[(3*16+1)*8 +: 8], 8'h00);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule